// File: doc/BRIEF.md
# Flag-Producing Arithmetic-Logic Unit with Barrel Shifter

This block is a purely combinational 32-bit arithmetic-logic unit for a single-cycle processor datapath. Two operands, `opa` and `opb`, enter together with a 5-bit function code. The code picks one of four sub-units: the add/subtract unit, the Boolean unit, a bidirectional barrel shifter, or a compare path. The selected value is driven on `res`. Four status flags come with it: negative, signed overflow, carry/borrow and zero.

The shifter moves `opb` by the count held in the low five bits of `opa`. This matches how a variable-shift instruction routes its operands. The compare path sets the result to 0 or 1 from a subtraction `opa − opb`, which is what set-on-less-than instructions need. Signed and unsigned less-than are also offered as separate outputs for branch logic.

The function code is laid out as follows:
- `fn[4:3]` selects the unit: 00 arithmetic, 01 Boolean, 10 shift, 11 compare.
- `fn[2]` requests subtraction.
- `fn[1:0]` selects the operation inside the Boolean or shift unit, or the signedness of the compare.

Top module: `alu_flagged`

## Requirements
- R1: With `fn[4:3]`=00 and `fn[2]`=0, `res` equals `opa + opb` modulo 2^32, and `flag_c` is the carry out of bit 31.
- R2: With `fn[4:3]`=00 and `fn[2]`=1, `res` equals `opa − opb` modulo 2^32, and `flag_c` is a borrow: 1 exactly when `opa < opb` unsigned.
- R3: In arithmetic and compare modes, `flag_v` is 1 exactly when the signed result of the addition or subtraction does not fit in 32 bits.
- R4: With `fn[4:3]`=01, `res` is `opa AND opb` for `fn[1:0]`=00, `OR` for 01, `XOR` for 10 and `NOR` for 11.
- R5: With `fn[4:3]`=10, `res` is `opb` shifted logically right for `fn[1:0]`=01 and arithmetically right (sign fill) for 11. For 00 and 10 it is shifted left with zero fill.
- R6: The shift count is `opa[4:0]`; the upper 27 bits of `opa` have no effect on a shift result.
- R7: `flag_z` is 1 exactly when `res` is all zeros, and `flag_n` equals `res[31]`, in every mode.
- R8: Whenever the unit is subtracting (`fn[2]`=1 in arithmetic mode, or compare mode), `lt_s` equals signed `opa < opb` (formed as N XOR V of the difference) and `lt_u` equals unsigned `opa < opb` (the borrow).
- R9: With `fn[4:3]`=11, the adder subtracts regardless of `fn[2]`, and `res` is the zero-extended less-than bit: unsigned when `fn[0]`=1, signed when `fn[0]`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand; low 5 bits are the shift count |
| opb | input | 32 | Second operand; the value shifted by the shifter |
| fn | input | 5 | Function code (unit select, subtract, sub-operation) |
| res | output | 32 | Result of the selected unit |
| flag_n | output | 1 | Sign bit of `res` |
| flag_v | output | 1 | Signed overflow of the add/subtract unit |
| flag_c | output | 1 | Carry on addition, borrow on subtraction |
| flag_z | output | 1 | `res` is all zeros |
| lt_s | output | 1 | Signed less-than from the subtraction |
| lt_u | output | 1 | Unsigned less-than from the subtraction |

## Verification
The block holds no state, so any fault inside it is visible at the ports in the same evaluation as the input change that exposes it. A miswired shifter stage appears only for shift counts with that stage's bit set, so the bench walks counts that cover every power of two and their combinations. A wrong subtract inversion or carry-in distorts `res`, the borrow and both less-than outputs together. Operand pairs at the signed and unsigned boundaries separate a wrong overflow rule from a wrong borrow rule. Flags taken from the wrong sub-unit show up as a zero or negative flag that disagrees with the visible result in Boolean and shift modes.

// File: rtl/alu_flagged_pkg.sv
package alu_flagged_pkg;

   typedef enum logic [1:0] {
      UNIT_ARITH = 2'b00,
      UNIT_BOOL  = 2'b01,
      UNIT_SHIFT = 2'b10,
      UNIT_CMP   = 2'b11
   } unit_e;

   typedef enum logic [1:0] {
      BOP_AND = 2'b00,
      BOP_OR  = 2'b01,
      BOP_XOR = 2'b10,
      BOP_NOR = 2'b11
   } bool_op_e;

   localparam int FN_W = 5;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         carry,
   output logic         ovf
);
   logic [W-1:0] b_eff;
   logic [W:0]   wide;

   always_comb begin
      b_eff = sub ? ~b : b;
      wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
      sum   = wide[W-1:0];
      // borrow convention: on subtraction a clear carry-out means a borrow
      carry = sub ? ~wide[W] : wide[W];
      ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
   end

   always_comb begin
      if (!$isunknown({a, b, sub})) begin
         if (sub) begin
            assert_borrow_is_ult_R2: assert (carry == (a < b))
               else $error("borrow disagrees with unsigned compare");
            assert_diff_value_R2: assert (sum == W'(a - b))
               else $error("difference wrong");
         end else begin
            assert_sum_value_R1: assert (sum == W'(a + b))
               else $error("sum wrong");
         end
      end
   end
endmodule

// File: rtl/alu_boolean.sv
module alu_boolean
   import alu_flagged_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  bool_op_e     op,
   output logic [W-1:0] y
);
   always_comb begin
      unique case (op)
         BOP_AND: y = a & b;
         BOP_OR:  y = a | b;
         BOP_XOR: y = a ^ b;
         BOP_NOR: y = ~(a | b);
         default: y = '0;
      endcase
   end

   always_comb begin
      if (!$isunknown({a, b, op}) && op == BOP_XOR) begin
         assert_xor_partition_R4: assert ((y & (a & b)) == '0)
            else $error("xor kept a common bit");
      end
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int W  = 32,
   parameter int SW = $clog2(W)
) (
   input  logic [W-1:0]  val,
   input  logic [SW-1:0] amt,
   input  logic          left,
   input  logic          arith,
   output logic [W-1:0]  out
);
   logic            fill;
   logic [W-1:0]    pre;
   logic [W-1:0]    stage [SW+1];

   assign fill = arith & ~left & val[W-1];

   // left shift = reverse, shift right, reverse back
   for (genvar i = 0; i < W; i++) begin : g_pre
      assign pre[i] = left ? val[W-1-i] : val[i];
   end

   assign stage[0] = pre;

   for (genvar k = 0; k < SW; k++) begin : g_stage
      localparam int S = 1 << k;
      assign stage[k+1] = amt[k] ? {{S{fill}}, stage[k][W-1:S]} : stage[k];
   end

   for (genvar i = 0; i < W; i++) begin : g_post
      assign out[i] = left ? stage[SW][W-1-i] : stage[SW][i];
   end

   always_comb begin
      if (!$isunknown({val, amt, left, arith})) begin
         if (left) begin
            assert_shl_R5: assert (out == (val << amt))
               else $error("left shift wrong");
         end else if (arith) begin
            assert_sra_R5: assert (out == W'($signed(val) >>> amt))
               else $error("arithmetic right shift wrong");
         end else begin
            assert_srl_R5: assert (out == (val >> amt))
               else $error("logical right shift wrong");
         end
      end
   end
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
   import alu_flagged_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [31:0] opa,
   input  logic [31:0] opb,
   input  logic [4:0]  fn,
   output logic [31:0] res,
   output logic        flag_n,
   output logic        flag_v,
   output logic        flag_c,
   output logic        flag_z,
   output logic        lt_s,
   output logic        lt_u
);
   localparam int SW = $clog2(W);

   initial begin
      assert_width_ok: assert (W == 32 && FN_W == 5)
         else $fatal(1, "alu_flagged port widths require W == 32");
   end

   unit_e        unit;
   logic         do_sub;
   logic [W-1:0] arith_y, bool_y, shift_y, cmp_y;
   logic         add_c, add_v;

   assign unit   = unit_e'(fn[4:3]);
   assign do_sub = fn[2] | (unit == UNIT_CMP);

   alu_addsub #(.W(W)) u_addsub (
      .a(opa), .b(opb), .sub(do_sub),
      .sum(arith_y), .carry(add_c), .ovf(add_v)
   );

   alu_boolean #(.W(W)) u_bool (
      .a(opa), .b(opb), .op(bool_op_e'(fn[1:0])), .y(bool_y)
   );

   alu_shifter #(.W(W), .SW(SW)) u_shift (
      .val(opb), .amt(opa[SW-1:0]),
      .left(~fn[0]), .arith(fn[1]),
      .out(shift_y)
   );

   assign lt_s  = arith_y[W-1] ^ add_v;
   assign lt_u  = add_c;
   assign cmp_y = {{(W-1){1'b0}}, fn[0] ? lt_u : lt_s};

   always_comb begin
      unique case (unit)
         UNIT_ARITH: res = arith_y;
         UNIT_BOOL:  res = bool_y;
         UNIT_SHIFT: res = shift_y;
         UNIT_CMP:   res = cmp_y;
         default:    res = '0;
      endcase
   end

   assign flag_n = res[W-1];
   assign flag_z = ~|res;
   assign flag_v = add_v;
   assign flag_c = add_c;

   always_comb begin
      if (!$isunknown({opa, opb, fn})) begin
         if (do_sub) begin
            assert_lt_signed_R8: assert (lt_s == ($signed(opa) < $signed(opb)))
               else $error("signed less-than wrong");
            assert_lt_unsigned_R8: assert (lt_u == (opa < opb))
               else $error("unsigned less-than wrong");
         end
         if (unit == UNIT_CMP) begin
            assert_cmp_bool_R9: assert (res[W-1:1] == '0)
               else $error("compare result not 0/1");
         end
         assert_zero_flag_R7: assert (!(flag_z && flag_n))
            else $error("zero and negative together");
      end
   end
endmodule

// File: tb/tb_alu_flagged.sv
module tb_alu_flagged;
   logic        clk = 0;
   logic        rst = 1;
   logic [31:0] opa = '0, opb = '0;
   logic [4:0]  fn = '0;
   logic [31:0] res;
   logic        flag_n, flag_v, flag_c, flag_z, lt_s, lt_u;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   alu_flagged dut (
      .opa(opa), .opb(opb), .fn(fn), .res(res),
      .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c), .flag_z(flag_z),
      .lt_s(lt_s), .lt_u(lt_u)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // apply one operation and check every output against values derived from requirements
   task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                      input logic [4:0] f);
      logic [31:0] e_res;
      logic        e_c, e_v, sub, slt, ult;
      longint      wide;
      logic [4:0]  sh;
      sub = f[2] | (f[4:3] == 2'b11);
      sh  = a[4:0];
      slt = $signed(a) < $signed(b);
      ult = a < b;
      if (sub) begin
         wide = longint'($signed(a)) - longint'($signed(b));
         e_c  = ult;
      end else begin
         wide = longint'($signed(a)) + longint'($signed(b));
         e_c  = ({1'b0, a} + {1'b0, b}) > 33'h0_FFFF_FFFF;
      end
      e_v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      case (f[4:3])
         2'b00: e_res = sub ? a - b : a + b;
         2'b01: case (f[1:0])
                   2'b00: e_res = a & b;
                   2'b01: e_res = a | b;
                   2'b10: e_res = a ^ b;
                   default: e_res = ~(a | b);
                endcase
         2'b10: case (f[1:0])
                   2'b01: e_res = b >> sh;
                   2'b11: e_res = 32'($signed(b) >>> sh);
                   default: e_res = b << sh;
                endcase
         default: e_res = {31'b0, f[0] ? ult : slt};
      endcase
      @(posedge clk);
      opa = a; opb = b; fn = f;
      @(negedge clk);
      chk(req, "res", res, e_res);
      chk("R7", "flag_z", {31'b0, flag_z}, {31'b0, e_res == 32'b0});
      chk("R7", "flag_n", {31'b0, flag_n}, {31'b0, e_res[31]});
      if (f[4:3] == 2'b00 || f[4:3] == 2'b11) begin
         chk(sub ? "R2" : "R1", "flag_c", {31'b0, flag_c}, {31'b0, e_c});
         chk("R3", "flag_v", {31'b0, flag_v}, {31'b0, e_v});
      end
      if (sub) begin
         chk("R8", "lt_s", {31'b0, lt_s}, {31'b0, slt});
         chk("R8", "lt_u", {31'b0, lt_u}, {31'b0, ult});
      end
   endtask

   task automatic t_idle;   // all-zero inputs: add of zeros
      run("R7", 32'h0, 32'h0, 5'b00000);
   endtask

   task automatic t_add;    // R1 R3
      run("R1", 32'h0000_0005, 32'h0000_0007, 5'b00000);
      run("R1", 32'hFFFF_FFFF, 32'h0000_0001, 5'b00000);
      run("R3", 32'h7FFF_FFFF, 32'h0000_0001, 5'b00000);
      run("R3", 32'h8000_0000, 32'h8000_0000, 5'b00000);
      run("R1", 32'h1234_5678, 32'h8765_4321, 5'b00011);
   endtask

   task automatic t_sub;    // R2 R3 R8
      run("R2", 32'h0000_0009, 32'h0000_0003, 5'b00100);
      run("R2", 32'h0000_0003, 32'h0000_0009, 5'b00100);
      run("R2", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'b00100);
      run("R3", 32'h8000_0000, 32'h0000_0001, 5'b00100);
      run("R3", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'b00100);
      run("R8", 32'hFFFF_FFFE, 32'h0000_0002, 5'b00100);
   endtask

   task automatic t_bool;   // R4
      for (int op = 0; op < 4; op++) begin
         run("R4", 32'hF0F0_CC33, 32'hFF00_A5A5, {3'b010, 2'(op)});
      end
      run("R4", 32'hFFFF_FFFF, 32'h0000_0000, 5'b01011);
   endtask

   task automatic t_shift;  // R5
      for (int s = 0; s < 32; s += 5) begin
         run("R5", 32'(s), 32'h8123_4567, 5'b10000);
         run("R5", 32'(s), 32'h8123_4567, 5'b10001);
         run("R5", 32'(s), 32'h8123_4567, 5'b10011);
         run("R5", 32'(s), 32'h4123_4567, 5'b10011);
      end
      run("R5", 32'd31, 32'h0000_0001, 5'b10010);
      run("R5", 32'd1,  32'hFFFF_FFFF, 5'b10000);
   endtask

   task automatic t_shamt;  // R6: upper operand bits ignored
      run("R6", 32'hFFFF_FFE4, 32'hCAFE_F00D, 5'b10001);
      run("R6", 32'hAAAA_AA00, 32'hCAFE_F00D, 5'b10000);
      run("R6", 32'h8000_0003, 32'h8000_0000, 5'b10011);
   endtask

   task automatic t_flags;  // R7 across units
      run("R7", 32'h0F0F_0F0F, 32'hF0F0_F0F0, 5'b01000);
      run("R7", 32'h0000_0000, 32'h0000_0000, 5'b01011);
      run("R7", 32'd4, 32'h0000_000F, 5'b10001);
   endtask

   task automatic t_cmp;    // R9 R8
      run("R9", 32'hFFFF_FFFF, 32'h0000_0001, 5'b11000);
      run("R9", 32'hFFFF_FFFF, 32'h0000_0001, 5'b11001);
      run("R9", 32'h0000_0001, 32'hFFFF_FFFF, 5'b11000);
      run("R9", 32'h0000_0001, 32'hFFFF_FFFF, 5'b11001);
      run("R9", 32'h8000_0000, 32'h7FFF_FFFF, 5'b11000);
      run("R9", 32'h0000_0005, 32'h0000_0005, 5'b11001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      t_idle();
      t_add();
      t_sub();
      t_bool();
      t_shift();
      t_shamt();
      t_flags();
      t_cmp();
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule